// File: doc/BRIEF.md
# Opcode Precondition Priority Dispatcher

Before the next opcode is issued, the sequencer checks for global conditions that must be handled first. These are a reset request, two interrupt lines, a stack-overflow trap, a reference-count trap, an output interrupt, and an invalid-opcode flag. This block picks the most urgent of the pending conditions and turns it into an 8-bit dispatch address. When nothing is pending, the fetched opcode passes through unchanged and is used as the dispatch address.

Each condition owns one bit of the lower seven address bits, and the top bit is always set. Handler entry points therefore fall between 128 and 255, and no two of them collide. The choice is captured only when the dispatch strobe is high. It is then held on the outputs until the next strobe, so the microcode sequencer sees a stable address for the whole opcode.

Top module: `precond_dispatch`

## Requirements
- R1: While `rstN` is low, `dispatchAddr` is 0 and `precondTaken` is 0.
- R2: If no unmasked condition is pending when the strobe is sampled high, then one clock later `dispatchAddr` equals the sampled `fetchedOp` and `precondTaken` is 0.
- R3: Condition priority runs from highest to lowest in this order: resetCond (index 0), irq1Req (1), irq2Req (2), stackOvfReq (3), refCountReq (4), outIrqReq (5), badOpcode (6). When several are pending, only the highest one is dispatched.
- R4: A taken condition with index k gives `dispatchAddr` = 128 + 2^k. The addresses are 129, 130, 132, 136, 144, 160 and 192, and `precondTaken` is 1.
- R5: badOpcode is dispatched (address 192) only when no other unmasked condition is pending.
- R6: While `intEnable` is 0, irq1Req, irq2Req and outIrqReq are ignored. resetCond, stackOvfReq, refCountReq and badOpcode are never masked.
- R7: In a cycle where the strobe was low, `dispatchAddr` and `precondTaken` keep their previous values, whatever the other inputs do.
- R8: Whenever `precondTaken` is 1, bit 7 of `dispatchAddr` is 1 and exactly one of bits 6..0 is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dispatchStrobe | input | 1 | Samples conditions and opcode for the next dispatch |
| intEnable | input | 1 | Enables the three interrupt conditions |
| resetCond | input | 1 | Reset precondition request |
| irq1Req | input | 1 | Interrupt 1 request |
| irq2Req | input | 1 | Interrupt 2 request |
| stackOvfReq | input | 1 | Stack-overflow detection |
| refCountReq | input | 1 | Reference-count trap detection |
| outIrqReq | input | 1 | Output interrupt request |
| badOpcode | input | 1 | Fetched opcode is not valid |
| fetchedOp | input | 8 | Opcode from the instruction fetch |
| dispatchAddr | output | 8 | Registered dispatch address |
| precondTaken | output | 1 | Registered flag: a precondition won the last dispatch |

## Verification
The assertions read the strobe, the condition inputs and the opcode one cycle back. They therefore assume these inputs are steady and meaningful at each sampling edge, and that the strobe stays low while reset is applied. The stimulus changes every input on the falling clock edge, so each input holds for a full cycle around the rising edge. Reset is applied with the strobe held at 0. The hold checks toggle every condition and the opcode while the strobe is low, which tests the stability property with real activity on the inputs.

// File: rtl/precond_pkg.sv
package precond_pkg;

  localparam int COND_COUNT  = 7;
  localparam int OPCODE_BITS = 8;

  // Condition index doubles as priority rank (0 is most urgent)
  typedef enum int {
    CND_RESET   = 0,
    CND_IRQ1    = 1,
    CND_IRQ2    = 2,
    CND_STKOVF  = 3,
    CND_REFCNT  = 4,
    CND_OUTIRQ  = 5,
    CND_BADOP   = 6
  } condIdx_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadEn;
    logic takeCond;
  } dispStrobes_t;

endpackage

// File: rtl/precond_ctrl.sv
module precond_ctrl
  import precond_pkg::*;
#(
  parameter int                    NUM_COND = COND_COUNT,
  parameter logic [NUM_COND-1:0]   MASKABLE = 7'b0100110
) (
  input  logic                dispatchStrobe,
  input  logic                intEnable,
  input  logic [NUM_COND-1:0] condRaw,
  output logic [NUM_COND-1:0] grant,
  output dispStrobes_t        strobes
);

  logic [NUM_COND-1:0] condEff;

  genvar i;
  generate
    for (i = 0; i < NUM_COND; i++) begin : g_mask
      if (MASKABLE[i]) begin : g_gated
        assign condEff[i] = condRaw[i] & intEnable;
      end else begin : g_open
        assign condEff[i] = condRaw[i];
      end
    end

    for (i = 0; i < NUM_COND; i++) begin : g_prio
      if (i == 0) begin : g_top
        assign grant[i] = condEff[i];
      end else begin : g_lower
        assign grant[i] = condEff[i] & ~(|condEff[i-1:0]);
      end
    end
  endgenerate

  always_comb begin
    strobes.loadEn   = dispatchStrobe;
    strobes.takeCond = |condEff;
  end

endmodule

// File: rtl/precond_datapath.sv
module precond_datapath
  import precond_pkg::*;
#(
  parameter int NUM_COND = COND_COUNT,
  parameter int OP_W     = OPCODE_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  dispStrobes_t        strobes,
  input  logic [NUM_COND-1:0] grant,
  input  logic [OP_W-1:0]     fetchedOp,
  output logic [OP_W-1:0]     dispatchAddr,
  output logic                precondTaken
);

  localparam int          PAD_W     = OP_W - NUM_COND;
  localparam logic [OP_W-1:0] UPPER_BASE = {1'b1, {(OP_W-1){1'b0}}};

  logic [OP_W-1:0] slotAddr;
  logic [OP_W-1:0] nextAddr;

  assign slotAddr = UPPER_BASE | {{PAD_W{1'b0}}, grant};
  assign nextAddr = strobes.takeCond ? slotAddr : fetchedOp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dispatchAddr <= '0;
      precondTaken <= 1'b0;
    end else if (strobes.loadEn) begin
      dispatchAddr <= nextAddr;
      precondTaken <= strobes.takeCond;
    end
  end

endmodule

// File: rtl/precond_dispatch.sv
module precond_dispatch
  import precond_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       dispatchStrobe,
  input  logic       intEnable,
  input  logic       resetCond,
  input  logic       irq1Req,
  input  logic       irq2Req,
  input  logic       stackOvfReq,
  input  logic       refCountReq,
  input  logic       outIrqReq,
  input  logic       badOpcode,
  input  logic [7:0] fetchedOp,
  output logic [7:0] dispatchAddr,
  output logic       precondTaken
);

  logic [COND_COUNT-1:0] condRaw;
  logic [COND_COUNT-1:0] grant;
  dispStrobes_t          strobes;

  always_comb begin
    condRaw             = '0;
    condRaw[CND_RESET]  = resetCond;
    condRaw[CND_IRQ1]   = irq1Req;
    condRaw[CND_IRQ2]   = irq2Req;
    condRaw[CND_STKOVF] = stackOvfReq;
    condRaw[CND_REFCNT] = refCountReq;
    condRaw[CND_OUTIRQ] = outIrqReq;
    condRaw[CND_BADOP]  = badOpcode;
  end

  precond_ctrl #(
    .NUM_COND (COND_COUNT),
    .MASKABLE (7'b0100110)
  ) ctrl_i (
    .dispatchStrobe (dispatchStrobe),
    .intEnable      (intEnable),
    .condRaw        (condRaw),
    .grant          (grant),
    .strobes        (strobes)
  );

  precond_datapath #(
    .NUM_COND (COND_COUNT),
    .OP_W     (OPCODE_BITS)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .grant        (grant),
    .fetchedOp    (fetchedOp),
    .dispatchAddr (dispatchAddr),
    .precondTaken (precondTaken)
  );

endmodule

// File: rtl/precond_dispatch_chk.sv
module precond_dispatch_chk (
  input logic       clk,
  input logic       rstN,
  input logic       dispatchStrobe,
  input logic       intEnable,
  input logic       resetCond,
  input logic       irq1Req,
  input logic       irq2Req,
  input logic       stackOvfReq,
  input logic       refCountReq,
  input logic       outIrqReq,
  input logic       badOpcode,
  input logic [7:0] fetchedOp,
  input logic [7:0] dispatchAddr,
  input logic       precondTaken
);

  logic unmaskedAny;
  logic nonBadPending;
  assign nonBadPending = resetCond | stackOvfReq | refCountReq |
                         (intEnable & (irq1Req | irq2Req | outIrqReq));
  assign unmaskedAny   = nonBadPending | badOpcode;

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(dispatchStrobe) |-> ($stable(dispatchAddr) && $stable(precondTaken)));

  assert_slot_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    precondTaken |-> (dispatchAddr[7] && $countones(dispatchAddr[6:0]) == 1));

  assert_reset_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(dispatchStrobe && resetCond) |-> (precondTaken && dispatchAddr == 8'd129));

  assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(dispatchStrobe && !unmaskedAny) |->
      (!precondTaken && dispatchAddr == $past(fetchedOp)));

  assert_bad_lowest_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(dispatchStrobe && nonBadPending) |-> (dispatchAddr != 8'd192));

  assert_masked_irq_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(dispatchStrobe && !intEnable && !resetCond && !stackOvfReq &&
          !refCountReq && !badOpcode) |-> !precondTaken);

  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_state_R1: assert (dispatchAddr == 8'd0 && !precondTaken);
    end
  end

endmodule

bind precond_dispatch precond_dispatch_chk chk_i (
  .clk            (clk),
  .rstN           (rstN),
  .dispatchStrobe (dispatchStrobe),
  .intEnable      (intEnable),
  .resetCond      (resetCond),
  .irq1Req        (irq1Req),
  .irq2Req        (irq2Req),
  .stackOvfReq    (stackOvfReq),
  .refCountReq    (refCountReq),
  .outIrqReq      (outIrqReq),
  .badOpcode      (badOpcode),
  .fetchedOp      (fetchedOp),
  .dispatchAddr   (dispatchAddr),
  .precondTaken   (precondTaken)
);

// File: tb/precond_dispatch_tb.sv
`timescale 1ns/1ps
module precond_dispatch_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       dispatchStrobe = 1'b0;
  logic       intEnable = 1'b0;
  logic [6:0] condV = '0;   // index order as in R3
  logic [7:0] fetchedOp = '0;
  logic [7:0] dispatchAddr;
  logic       precondTaken;

  int vecCount = 0;
  int errCount = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  precond_dispatch dut_i (
    .clk            (clk),
    .rstN           (rstN),
    .dispatchStrobe (dispatchStrobe),
    .intEnable      (intEnable),
    .resetCond      (condV[0]),
    .irq1Req        (condV[1]),
    .irq2Req        (condV[2]),
    .stackOvfReq    (condV[3]),
    .refCountReq    (condV[4]),
    .outIrqReq      (condV[5]),
    .badOpcode      (condV[6]),
    .fetchedOp      (fetchedOp),
    .dispatchAddr   (dispatchAddr),
    .precondTaken   (precondTaken)
  );

  // Reference from R3/R4/R6: returns {taken, addr}
  function automatic logic [8:0] refModel(input logic [6:0] c, input logic ie,
                                          input logic [7:0] op);
    logic [6:0] eff;
    eff = ie ? c : (c & ~7'b0100110);
    for (int k = 0; k < 7; k++)
      if (eff[k]) return {1'b1, 8'd128 + (8'd1 << k)};
    return {1'b0, op};
  endfunction

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    vecCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s: taken/addr actual=%0d/%0d expected=%0d/%0d",
               tag, act[8], act[7:0], exp[8], exp[7:0]);
    end
  endtask

  task automatic dispatch(input string tag, input logic [6:0] c, input logic ie,
                          input logic [7:0] op);
    @(negedge clk);
    condV = c; intEnable = ie; fetchedOp = op; dispatchStrobe = 1'b1;
    @(negedge clk);
    dispatchStrobe = 1'b0;
    check(tag, {precondTaken, dispatchAddr}, refModel(c, ie, op));
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset", {precondTaken, dispatchAddr}, 9'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", {precondTaken, dispatchAddr}, 9'd0);
  endtask

  task automatic testPassThrough();
    dispatch("R2 op 0x00", 7'd0, 1'b1, 8'h00);
    dispatch("R2 op 0x5A", 7'd0, 1'b0, 8'h5A);
    dispatch("R2 op 0xFF", 7'd0, 1'b1, 8'hFF);
    dispatch("R2 op 0x81", 7'd0, 1'b1, 8'h81);
  endtask

  task automatic testEachSlot();
    for (int k = 0; k < 7; k++)
      dispatch("R4 single condition", 7'd1 << k, 1'b1, 8'h33);
  endtask

  task automatic testPriority();
    dispatch("R3 all pending", 7'h7F, 1'b1, 8'h10);
    dispatch("R3 irq1 over irq2+ovf", 7'b0001110, 1'b1, 8'h11);
    dispatch("R3 ovf over refcnt+outirq", 7'b0111000, 1'b1, 8'h12);
    dispatch("R3 refcnt over outirq", 7'b0110000, 1'b1, 8'h13);
    for (int m = 1; m < 128; m += 9)
      dispatch("R3 mixed set", m[6:0], 1'b1, 8'h20 + m[7:0]);
  endtask

  task automatic testBadLowest();
    dispatch("R5 bad alone", 7'b1000000, 1'b1, 8'h44);
    dispatch("R5 bad with outirq", 7'b1100000, 1'b1, 8'h45);
    dispatch("R5 bad with masked irq", 7'b1000010, 1'b0, 8'h46);
  endtask

  task automatic testMasking();
    dispatch("R6 irqs masked", 7'b0100110, 1'b0, 8'h6C);
    dispatch("R6 outirq masked", 7'b0100000, 1'b0, 8'h6D);
    dispatch("R6 reset unmasked", 7'b0000001, 1'b0, 8'h6E);
    dispatch("R6 ovf under mask", 7'b0001010, 1'b0, 8'h6F);
    dispatch("R6 refcnt under mask", 7'b0010100, 1'b0, 8'h70);
  endtask

  task automatic testHold();
    logic [8:0] held;
    dispatch("R7 setup", 7'b0001000, 1'b1, 8'h01);
    held = {precondTaken, dispatchAddr};
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      condV = 7'h7F ^ j[6:0]; intEnable = j[0]; fetchedOp = 8'hC0 + j[7:0];
      @(negedge clk);
      check("R7 hold", {precondTaken, dispatchAddr}, held);
    end
    dispatch("R7 setup pass", 7'd0, 1'b1, 8'h3C);
    held = {precondTaken, dispatchAddr};
    @(negedge clk);
    condV = 7'h01; fetchedOp = 8'h99;
    repeat (2) @(negedge clk);
    check("R7 hold opcode", {precondTaken, dispatchAddr}, held);
    condV = '0;
  endtask

  task automatic testSlotShape();
    for (int m = 1; m < 128; m += 5) begin
      dispatch("R8 slot shape", m[6:0], 1'b1, 8'h00);
      vecCount++;
      if (!(dispatchAddr[7] && $countones(dispatchAddr[6:0]) == 1)) begin
        errCount++;
        $display("FAIL R8: actual addr=%0d expected one-hot upper slot", dispatchAddr);
      end
    end
  endtask

  task automatic testMidReset();
    dispatch("R1 pre", 7'b0000100, 1'b1, 8'h00);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", {precondTaken, dispatchAddr}, 9'd0);
    rstN = 1'b1;
  endtask

  initial begin
    testReset();
    testPassThrough();
    testEachSlot();
    testPriority();
    testBadLowest();
    testMasking();
    testHold();
    testSlotShape();
    testMidReset();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vecCount++;
      errCount++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  end

endmodule